// File: doc/BRIEF.md
# Parallel Instruction Boundary Finder

This block sits in the front end of a processor whose instructions vary in length. Each cycle it may receive one aligned 16-byte line of code. A small length decoder is placed at every byte offset of the line, and all sixteen decoders evaluate at the same time. Each one assumes that an instruction starts at its own offset. A selection chain then starts from the offset where decoding is known to resume. It hops from one real start to the next, using the lengths that have already been computed, and hands out up to four complete instructions per pass. Every decoder result that does not lie on the chain is discarded.

The encoding is deliberately simple. A first byte of 0x0F is an escape, which means a second opcode byte follows. Bits [7:6] of the opcode byte that decides the length choose how many immediate bytes trail the instruction. An instruction can cross into the next line. In that case it is reported as pending instead of being emitted, and the resume point for the next line is carried in a register. If four instructions fill a pass and bytes of the line remain, the block asks for the same line again. A flush sets the resume point to any chosen offset in the line that comes next.

Top module: `insn_boundary_finder`

## Requirements
- R1: Byte p of the line is `i_line[8p+7:8p]`. If an instruction starts with 0x0F, its length is 2 plus the immediate size taken from bits [7:6] of the following byte. Any other first byte gives a length of 1 plus the immediate size taken from its own bits [7:6]. The immediate size is 0, 1, 2 or 4 bytes for the codes 00, 01, 10 and 11.
- R2: Slot 0 holds the instruction at the chain start. Slot k+1 starts where slot k ends. The valid slots always form a contiguous group that begins at slot 0. Offsets are 4-bit fields packed at `o_slot_off[4k+3:4k]`. Lengths are 3-bit fields packed at `o_slot_len[3k+2:3k]`.
- R3: One pass emits at most four instructions. If all four are emitted and the fourth one ends before byte 16, then `o_same_line` is 1 and `o_resume_off` gives the offset in the same line where decoding continues.
- R4: An instruction that does not end within the line is never emitted. Instead `o_straddle` is 1, `o_strad_off` gives its start, and `o_resume_off` equals its end minus 16.
- R5: If an escape byte sits at offset 15, then `o_esc_wait` is 1 together with `o_straddle`. The next line's chain then starts at 1 plus the immediate size taken from bits [7:6] of that line's byte 0.
- R6: If the chain ends exactly at byte 16 with no more than four instructions, then `o_resume_off` is 0 and both `o_same_line` and `o_straddle` are 0.
- R7: `i_flush` sets the chain start to `i_flush_off` and cancels a pending escape. Given together with a line, it applies to that line. Given on its own, it applies to the next line.
- R8: Results are registered. `o_out_vld` is 1 in exactly the cycle after a cycle in which `i_line_vld` was 1, and 0 otherwise. All slot valid bits are 0 whenever `o_out_vld` is 0. Idle cycles leave the resume point unchanged.
- R9: Synchronous reset clears `o_out_vld` and all slot valid bits, sets the chain start to 0 and cancels any pending escape.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_clk | input | 1 | Clock |
| i_rst | input | 1 | Synchronous active-high reset |
| i_line_vld | input | 1 | A line is presented this cycle |
| i_line | input | 128 | Line bytes, byte p at bits [8p+7:8p] |
| i_flush | input | 1 | Restart the chain at i_flush_off |
| i_flush_off | input | 4 | Restart offset |
| o_out_vld | output | 1 | Result of the previous cycle's line |
| o_slot_vld | output | 4 | Valid bit per slot |
| o_slot_off | output | 16 | Start offset per slot |
| o_slot_len | output | 12 | Length per slot |
| o_resume_off | output | 4 | Where decoding continues |
| o_same_line | output | 1 | The same line must be presented again |
| o_straddle | output | 1 | An instruction crosses into the next line |
| o_strad_off | output | 4 | Start offset of that instruction |
| o_esc_wait | output | 1 | The crossing instruction is an escape at byte 15 |

## Verification
Every result appears one clock after the line that caused it. The bench drives a line on a falling edge and reads the outputs on the following falling edge, which lies half a period after the capturing edge. Between lines it checks on a falling edge that `o_out_vld` has gone back to 0. A flush given on its own is checked the same way, one cycle later. The effect of a carried resume point or a pending escape is judged in the result of the next line. The expected boundaries come from a walk, one instruction after another, over the whole byte stream. Each line's expected slots and tail are taken from that walk. A line is presented again whenever four instructions fill a pass and bytes of the line remain.

// File: rtl/ibf_pkg.sv
`timescale 1ns/1ps
package ibf_pkg;

    localparam logic [7:0] ESC_BYTE = 8'h0F;
    localparam int         LEN_W    = 3;   // lengths 1..6

    // per-offset speculative decode
    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             cut;   // escape whose second byte lies beyond the line
    } dec_t;

    // how a pass ended
    typedef enum logic [1:0] {
        TAIL_EXACT,   // chain ended on the line boundary
        TAIL_MORE,    // slots full, bytes left in this line
        TAIL_STRAD,   // next instruction crosses the line end
        TAIL_ESCCUT   // escape byte is the last byte of the line
    } tail_e;

    function automatic logic [LEN_W-1:0] imm_size(input logic [1:0] code);
        case (code)
            2'b00:   imm_size = LEN_W'(0);
            2'b01:   imm_size = LEN_W'(1);
            2'b10:   imm_size = LEN_W'(2);
            default: imm_size = LEN_W'(4);
        endcase
    endfunction

endpackage

// File: rtl/ibf_len_dec.sv
`timescale 1ns/1ps
module ibf_len_dec
    import ibf_pkg::*;
#(
    parameter bit HAS_NEXT = 1'b1
) (
    input  logic [7:0] i_b0,
    input  logic [7:0] i_b1,
    output dec_t       o_dec
);

    always_comb begin
        if (i_b0 == ESC_BYTE) begin
            o_dec.len = LEN_W'(2) + imm_size(i_b1[7:6]);
            o_dec.cut = !HAS_NEXT;
        end else begin
            o_dec.len = LEN_W'(1) + imm_size(i_b0[7:6]);
            o_dec.cut = 1'b0;
        end
    end

endmodule

// File: rtl/ibf_chain.sv
`timescale 1ns/1ps
module ibf_chain
    import ibf_pkg::*;
#(
    parameter int LINE_BYTES = 16,
    parameter int SLOTS      = 4,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int POS_W     = OFF_W + 1
) (
    input  logic [OFF_W-1:0] i_start,
    input  dec_t             i_dec [LINE_BYTES],
    output logic             o_vld [SLOTS],
    output logic [OFF_W-1:0] o_off [SLOTS],
    output logic [LEN_W-1:0] o_len [SLOTS],
    output tail_e            o_tail,
    output logic [OFF_W-1:0] o_resume,
    output logic [OFF_W-1:0] o_strad_off
);

    localparam logic [POS_W-1:0] LINE_END = POS_W'(LINE_BYTES);

    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] nxt;
    logic [POS_W-1:0] stop_pos;
    logic [POS_W-1:0] wrap;
    logic [LEN_W-1:0] stop_len;
    logic             stop_cut;
    logic             all_ok;
    logic             ok;
    logic             in_line;
    dec_t             cur;

    always_comb begin
        pos      = POS_W'(i_start);
        all_ok   = 1'b1;
        stop_pos = '0;
        stop_len = '0;
        stop_cut = 1'b0;
        nxt      = '0;
        ok       = 1'b0;
        in_line  = 1'b0;
        cur      = '0;
        for (int k = 0; k < SLOTS; k++) begin
            in_line  = pos < LINE_END;
            cur      = in_line ? i_dec[pos[OFF_W-1:0]] : '0;
            nxt      = pos + POS_W'(cur.len);
            ok       = all_ok && in_line && (nxt <= LINE_END);
            o_vld[k] = ok;
            o_off[k] = pos[OFF_W-1:0];
            o_len[k] = cur.len;
            if (all_ok && !ok) begin
                stop_pos = pos;
                stop_len = cur.len;
                stop_cut = cur.cut;
            end
            all_ok = ok;
            if (ok) pos = nxt;
        end

        o_strad_off = stop_pos[OFF_W-1:0];
        wrap        = '0;
        if (all_ok) begin
            if (pos < LINE_END) begin
                o_tail   = TAIL_MORE;
                o_resume = pos[OFF_W-1:0];
            end else begin
                o_tail   = TAIL_EXACT;
                wrap     = pos - LINE_END;
                o_resume = wrap[OFF_W-1:0];
            end
        end else if (stop_pos == LINE_END) begin
            o_tail   = TAIL_EXACT;
            o_resume = '0;
        end else if (stop_cut) begin
            o_tail   = TAIL_ESCCUT;
            o_resume = '0;
        end else begin
            o_tail   = TAIL_STRAD;
            wrap     = stop_pos + POS_W'(stop_len) - LINE_END;
            o_resume = wrap[OFF_W-1:0];
        end
    end

endmodule

// File: rtl/ibf_start_ctl.sv
`timescale 1ns/1ps
module ibf_start_ctl
    import ibf_pkg::*;
#(
    parameter int LINE_BYTES = 16,
    localparam int OFF_W     = $clog2(LINE_BYTES)
) (
    input  logic             i_clk,
    input  logic             i_rst,
    input  logic             i_line_vld,
    input  logic             i_flush,
    input  logic [OFF_W-1:0] i_flush_off,
    input  logic [7:0]       i_head,
    input  logic [OFF_W-1:0] i_resume,
    input  logic             i_esc_cut,
    output logic [OFF_W-1:0] o_start
);

    logic [OFF_W-1:0] start_q;
    logic             esc_pend_q;

    always_comb begin
        if (i_flush)
            o_start = i_flush_off;
        else if (esc_pend_q)
            o_start = OFF_W'(1) + OFF_W'(imm_size(i_head[7:6]));
        else
            o_start = start_q;
    end

    always_ff @(posedge i_clk) begin
        if (i_rst) begin
            start_q    <= '0;
            esc_pend_q <= 1'b0;
        end else if (i_line_vld) begin
            start_q    <= i_resume;
            esc_pend_q <= i_esc_cut;
        end else if (i_flush) begin
            start_q    <= i_flush_off;
            esc_pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/insn_boundary_finder.sv
`timescale 1ns/1ps
module insn_boundary_finder
    import ibf_pkg::*;
#(
    parameter int LINE_BYTES = 16,
    parameter int SLOTS      = 4,
    localparam int OFF_W     = $clog2(LINE_BYTES)
) (
    input  logic                    i_clk,
    input  logic                    i_rst,
    input  logic                    i_line_vld,
    input  logic [LINE_BYTES*8-1:0] i_line,
    input  logic                    i_flush,
    input  logic [OFF_W-1:0]        i_flush_off,
    output logic                    o_out_vld,
    output logic [SLOTS-1:0]        o_slot_vld,
    output logic [SLOTS*OFF_W-1:0]  o_slot_off,
    output logic [SLOTS*LEN_W-1:0]  o_slot_len,
    output logic [OFF_W-1:0]        o_resume_off,
    output logic                    o_same_line,
    output logic                    o_straddle,
    output logic [OFF_W-1:0]        o_strad_off,
    output logic                    o_esc_wait
);

    logic [7:0]       line_b [LINE_BYTES];
    dec_t             dec    [LINE_BYTES];
    logic             c_vld  [SLOTS];
    logic [OFF_W-1:0] c_off  [SLOTS];
    logic [LEN_W-1:0] c_len  [SLOTS];
    tail_e            c_tail;
    logic [OFF_W-1:0] c_resume;
    logic [OFF_W-1:0] c_strad_off;
    logic [OFF_W-1:0] start;

    // one speculative length decoder per byte offset
    for (genvar p = 0; p < LINE_BYTES; p++) begin : g_dec
        assign line_b[p] = i_line[8*p +: 8];
        if (p < LINE_BYTES - 1) begin : g_mid
            ibf_len_dec #(.HAS_NEXT(1'b1)) u_dec (
                .i_b0 (i_line[8*p +: 8]),
                .i_b1 (i_line[8*(p+1) +: 8]),
                .o_dec(dec[p])
            );
        end else begin : g_last
            ibf_len_dec #(.HAS_NEXT(1'b0)) u_dec (
                .i_b0 (i_line[8*p +: 8]),
                .i_b1 (8'h00),
                .o_dec(dec[p])
            );
        end
    end

    ibf_start_ctl #(.LINE_BYTES(LINE_BYTES)) u_start (
        .i_clk      (i_clk),
        .i_rst      (i_rst),
        .i_line_vld (i_line_vld),
        .i_flush    (i_flush),
        .i_flush_off(i_flush_off),
        .i_head     (line_b[0]),
        .i_resume   (c_resume),
        .i_esc_cut  (c_tail == TAIL_ESCCUT),
        .o_start    (start)
    );

    ibf_chain #(.LINE_BYTES(LINE_BYTES), .SLOTS(SLOTS)) u_chain (
        .i_start    (start),
        .i_dec      (dec),
        .o_vld      (c_vld),
        .o_off      (c_off),
        .o_len      (c_len),
        .o_tail     (c_tail),
        .o_resume   (c_resume),
        .o_strad_off(c_strad_off)
    );

    always_ff @(posedge i_clk) begin
        if (i_rst) begin
            o_out_vld    <= 1'b0;
            o_slot_vld   <= '0;
            o_slot_off   <= '0;
            o_slot_len   <= '0;
            o_resume_off <= '0;
            o_same_line  <= 1'b0;
            o_straddle   <= 1'b0;
            o_strad_off  <= '0;
            o_esc_wait   <= 1'b0;
        end else if (i_line_vld) begin
            o_out_vld <= 1'b1;
            for (int k = 0; k < SLOTS; k++) begin
                o_slot_vld[k]                <= c_vld[k];
                o_slot_off[k*OFF_W +: OFF_W] <= c_off[k];
                o_slot_len[k*LEN_W +: LEN_W] <= c_len[k];
            end
            o_resume_off <= c_resume;
            o_same_line  <= (c_tail == TAIL_MORE);
            o_straddle   <= (c_tail == TAIL_STRAD) || (c_tail == TAIL_ESCCUT);
            o_strad_off  <= c_strad_off;
            o_esc_wait   <= (c_tail == TAIL_ESCCUT);
        end else begin
            o_out_vld  <= 1'b0;
            o_slot_vld <= '0;
        end
    end

endmodule

// File: rtl/ibf_chk.sv
`timescale 1ns/1ps
module ibf_chk
    import ibf_pkg::*;
#(
    parameter int LINE_BYTES = 16,
    parameter int SLOTS      = 4,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int PW        = OFF_W + 1
) (
    input logic                   i_clk,
    input logic                   i_rst,
    input logic                   i_line_vld,
    input logic                   o_out_vld,
    input logic [SLOTS-1:0]       o_slot_vld,
    input logic [SLOTS*OFF_W-1:0] o_slot_off,
    input logic [SLOTS*LEN_W-1:0] o_slot_len,
    input logic                   o_same_line,
    input logic                   o_straddle,
    input logic [OFF_W-1:0]       o_strad_off,
    input logic                   o_esc_wait
);

    // R9
    reset_clears_chk: assert property (@(posedge i_clk) disable iff (i_rst)
        $past(i_rst) |-> (!o_out_vld && o_slot_vld == '0));

    // R8
    out_follows_line_chk: assert property (@(posedge i_clk) disable iff (i_rst)
        i_line_vld |=> o_out_vld);

    // R8
    idle_quiet_chk: assert property (@(posedge i_clk) disable iff (i_rst)
        !i_line_vld |=> (!o_out_vld && o_slot_vld == '0));

    // R2
    slots_contig_chk: assert property (@(posedge i_clk) disable iff (i_rst)
        (o_slot_vld & SLOTS'(o_slot_vld + 1'b1)) == '0);

    // R3
    same_line_full_chk: assert property (@(posedge i_clk) disable iff (i_rst)
        (o_out_vld && o_same_line) |-> (&o_slot_vld));

    // R4
    straddle_excl_chk: assert property (@(posedge i_clk) disable iff (i_rst)
        (o_out_vld && o_straddle) |-> (!o_same_line && !(&o_slot_vld)));

    // R5
    esc_at_end_chk: assert property (@(posedge i_clk) disable iff (i_rst)
        (o_out_vld && o_esc_wait) |-> (o_straddle && o_strad_off == OFF_W'(LINE_BYTES - 1)));

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        // R1
        len_range_chk: assert property (@(posedge i_clk) disable iff (i_rst)
            o_slot_vld[k] |-> (o_slot_len[k*LEN_W +: LEN_W] >= LEN_W'(1) &&
                               o_slot_len[k*LEN_W +: LEN_W] <= LEN_W'(6)));
        // R4
        inside_line_chk: assert property (@(posedge i_clk) disable iff (i_rst)
            o_slot_vld[k] |-> (PW'(o_slot_off[k*OFF_W +: OFF_W]) +
                               PW'(o_slot_len[k*LEN_W +: LEN_W]) <= PW'(LINE_BYTES)));
        if (k < SLOTS - 1) begin : g_adj
            // R2
            adjacent_chk: assert property (@(posedge i_clk) disable iff (i_rst)
                o_slot_vld[k+1] |-> (PW'(o_slot_off[(k+1)*OFF_W +: OFF_W]) ==
                                     PW'(o_slot_off[k*OFF_W +: OFF_W]) +
                                     PW'(o_slot_len[k*LEN_W +: LEN_W])));
        end
    end

endmodule

bind insn_boundary_finder ibf_chk #(.LINE_BYTES(LINE_BYTES), .SLOTS(SLOTS)) u_chk (
    .i_clk      (i_clk),
    .i_rst      (i_rst),
    .i_line_vld (i_line_vld),
    .o_out_vld  (o_out_vld),
    .o_slot_vld (o_slot_vld),
    .o_slot_off (o_slot_off),
    .o_slot_len (o_slot_len),
    .o_same_line(o_same_line),
    .o_straddle (o_straddle),
    .o_strad_off(o_strad_off),
    .o_esc_wait (o_esc_wait)
);

// File: tb/sim_insn_boundary_finder.sv
`timescale 1ns/1ps
module sim_insn_boundary_finder;

    localparam int LB   = 16;
    localparam int NS   = 4;
    localparam int MAXB = LB * 12 + 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         line_vld = 1'b0;
    logic [127:0] line = '0;
    logic         flush = 1'b0;
    logic [3:0]   flush_off = '0;
    logic         out_vld;
    logic [3:0]   slot_vld;
    logic [15:0]  slot_off;
    logic [11:0]  slot_len;
    logic [3:0]   resume_off;
    logic         same_line;
    logic         straddle;
    logic [3:0]   strad_off;
    logic         esc_wait;

    insn_boundary_finder u0 (
        .i_clk(clk), .i_rst(rst), .i_line_vld(line_vld), .i_line(line),
        .i_flush(flush), .i_flush_off(flush_off),
        .o_out_vld(out_vld), .o_slot_vld(slot_vld), .o_slot_off(slot_off),
        .o_slot_len(slot_len), .o_resume_off(resume_off), .o_same_line(same_line),
        .o_straddle(straddle), .o_strad_off(strad_off), .o_esc_wait(esc_wait)
    );

    always #2.5 clk = ~clk;

    logic [7:0] mem [MAXB];
    int gst  [MAXB];
    int glen [MAXB];
    int gcnt, gend;
    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    function automatic int imm_of(input logic [1:0] c);
        return (c == 2'b11) ? 4 : int'(c);
    endfunction

    // R1 reference length
    function automatic int ref_len(input int a);
        if (mem[a] == 8'h0F) return 2 + imm_of(mem[a+1][7:6]);
        return 1 + imm_of(mem[a][7:6]);
    endfunction

    task automatic present(input int base, input bit fl, input int fo);
        @(negedge clk);
        chk_eq("R8 idle out_vld", int'(out_vld), 0);
        for (int p = 0; p < LB; p++) line[8*p +: 8] = mem[base + p];
        line_vld  = 1'b1;
        flush     = fl;
        flush_off = fo[3:0];
        @(negedge clk);
        line_vld = 1'b0;
        flush    = 1'b0;
    endtask

    // mode 0: no flush, 1: flush with first line, 2: flush alone before it
    task automatic run_phase(input int nlines, input int foff, input int mode,
                             input int kind, input int v);
        int tb_bytes, a, gi, li, base, endb, cnt, nx, so;
        bit first, esc;
        string tag;
        tb_bytes = nlines * LB;
        for (int i = 0; i < tb_bytes + LB; i++)
            mem[i] = ($urandom_range(0, 7) == 0) ? 8'h0F : 8'($urandom);
        if (kind == 1) mem[foff] = 8'(v);
        if (kind == 2) begin mem[foff] = 8'h0F; mem[foff+1] = 8'(v); end
        a = foff; gcnt = 0;
        while (a < tb_bytes) begin
            gst[gcnt] = a; glen[gcnt] = ref_len(a); a += glen[gcnt]; gcnt++;
        end
        gend = a;
        if (mode == 2) begin
            @(negedge clk);
            flush = 1'b1; flush_off = foff[3:0];
            @(negedge clk);
            flush = 1'b0;
            chk_eq("R7 flush alone gives no result", int'(out_vld), 0);
        end
        gi = 0; li = 0; first = 1'b1;
        while (li < nlines) begin
            base = li * LB; endb = base + LB;
            present(base, first && mode == 1, foff);
            tag = first ? ((mode == 0) ? "R9 start" : "R7 start") : "R2 slot";
            first = 1'b0;
            chk_eq("R8 out_vld", int'(out_vld), 1);
            cnt = 0;
            while (cnt < NS && gi + cnt < gcnt && gst[gi+cnt] + glen[gi+cnt] <= endb) cnt++;
            for (int k = 0; k < NS; k++) begin
                chk_eq({tag, " valid"}, int'(slot_vld[k]), int'(k < cnt));
                if (k < cnt) begin
                    chk_eq({tag, " offset"}, int'(slot_off[4*k +: 4]), gst[gi+k] - base);
                    chk_eq("R1 length", int'(slot_len[3*k +: 3]), glen[gi+k]);
                end
            end
            nx = gi + cnt;
            if (cnt == NS && nx < gcnt && gst[nx] < endb) begin
                chk_eq("R3 same_line", int'(same_line), 1);
                chk_eq("R3 resume", int'(resume_off), gst[nx] - base);
                chk_eq("R3 straddle", int'(straddle), 0);
                gi = nx;
            end else if (nx < gcnt && gst[nx] < endb) begin
                so  = gst[nx] - base;
                esc = (so == LB - 1) && (mem[gst[nx]] == 8'h0F);
                chk_eq("R4 straddle", int'(straddle), 1);
                chk_eq("R4 straddle offset", int'(strad_off), so);
                chk_eq("R4 same_line", int'(same_line), 0);
                chk_eq("R5 esc_wait", int'(esc_wait), int'(esc));
                if (!esc) chk_eq("R4 resume", int'(resume_off), gst[nx] + glen[nx] - endb);
                gi = nx + 1; li++;
            end else begin
                chk_eq("R6 straddle", int'(straddle), 0);
                chk_eq("R6 same_line", int'(same_line), 0);
                chk_eq("R6 resume", int'(resume_off), ((nx < gcnt) ? gst[nx] : gend) - endb);
                gi = nx; li++;
            end
        end
    endtask

    initial begin
        #(5.0 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R9 out_vld after reset", int'(out_vld), 0);
        chk_eq("R9 slot_vld after reset", int'(slot_vld), 0);
        run_phase(6, 0, 0, 0, 0);
        // R1 sweep of every opcode value, plain and behind an escape
        for (int v = 0; v < 256; v++) begin
            run_phase(1, v % 13, 1 + (v % 2), 1, v);
            run_phase(1, v % 16, 1 + ((v / 2) % 2), 2, v);
        end
        for (int n = 0; n < 300; n++)
            run_phase(6, $urandom_range(0, 15), $urandom_range(1, 2), 0, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule